// File: doc/BRIEF.md
# Carriage-Return Auto-Baud Detector

This block listens to a raw asynchronous receive line and works out its bit rate without being told. It times every high and low stretch of the line in system clocks. It waits for the exact shape that a carriage-return byte ($0D, eight data bits, least significant bit first, one start bit and one stop bit) makes when it follows a quiet line. When that shape turns up, the block reports the bit time in clocks for a neighbouring UART to use.

The block never stops listening. Each later carriage return that fits the shape measures the rate again and replaces the earlier value, so the reported period follows the system clock when it is raised or lowered. Each accepted run is compared with the start-bit length using integer bounds of plus or minus a quarter bit. The reported period is the sum of all five measured runs divided by nine, rounded. Averaging over the whole character reduces the effect of edge jitter on any one run.

Top module: `cr_autobaud`

## Requirements
- R1: While reset is asserted and after it is released, `bitPeriod` is 0, `periodValid` is 0 and `periodUpdate` is 0 until the first match.
- R2: The line passes through a two-stage synchronizer. The outputs change at the third rising clock edge after the rx transition that ends the last run of a match.
- R3: A match is the following run sequence: a high idle run, then low x, high x, low x, high 2x, low 4x. Here x is the length of the low start run in clocks.
- R4: Each run after the start run, with expected multiple k equal to 1, 1, 2 and 4 in order, is accepted only when (4k-1)·x ≤ 4·length ≤ (4k+1)·x. A run outside this range aborts the match.
- R5: The idle run before the start bit must be strictly longer than 8·x. An idle of exactly 8·x aborts the match.
- R6: On a match, `bitPeriod` is loaded with floor((S+4)/9), where S is the sum of the five runs from the start bit to the last low run.
- R7: A start run shorter than 4 clocks never begins a match.
- R8: Every later match replaces `bitPeriod`, whether the new value is higher or lower. Once `periodValid` is 1 it stays 1.
- R9: `periodUpdate` is high for exactly one clock on each load of `bitPeriod`. `bitPeriod` changes at no other time, and `periodValid` first rises together with `periodUpdate`.
- R10: The run counter saturates at 2^16-1 and does not wrap, so an idle run longer than 65535 clocks still qualifies.
- R11: A character whose run shape differs, such as a space ($20: low 6x, high x, low 2x), leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxPin | input | 1 | Raw asynchronous receive line, high when idle |
| bitPeriod | output | 16 | Measured bit time in clocks |
| periodValid | output | 1 | High once any period has been measured |
| periodUpdate | output | 1 | One-clock strobe when `bitPeriod` is loaded |

## Verification
The bench builds the block with its default parameters: a 16-bit run counter, a 4-clock glitch floor and two synchronizer stages. The 16-bit counter lets the bench drive an idle run of about 65,600 clocks within its run time, and a wrapping counter would then fail the idle test. The small glitch floor puts the 3-clock versus 4-clock boundary within easy reach. The bench also covers the 173-clock bit time, the exact quarter-bit tolerance limits, the rounding point of the divide by nine, and the strict idle bound.

// File: rtl/cr_autobaud_pkg.sv
package cr_autobaud_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_START,
    ST_B0,
    ST_B1,
    ST_B23,
    ST_B47
  } ctlState_t;

  // log2 of the expected multiple k for the run under test
  localparam logic [1:0] TOL_K1 = 2'd0;
  localparam logic [1:0] TOL_K2 = 2'd1;
  localparam logic [1:0] TOL_K4 = 2'd2;

  typedef struct packed {
    logic       loadIdle;
    logic       loadStart;
    logic       addRun;
    logic       commit;
    logic [1:0] tolSel;
  } ctlCmd_t;

  typedef struct packed {
    logic runDone;
    logic runLevel;
    logic startOk;
    logic idleOk;
    logic inTol;
  } dpStat_t;

endpackage

// File: rtl/cr_autobaud_dp.sv
module cr_autobaud_dp
  import cr_autobaud_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_START   = 4,
  parameter int IDLE_UNITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxPin,
  input  ctlCmd_t          cmd,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] bitPeriod,
  output logic             periodValid,
  output logic             periodUpdate
);

  localparam int EXT_W = CNT_W + 6;
  localparam int SUM_W = CNT_W + 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // synchronizer and edge detection
  logic [SYNC_STAGES-1:0] syncChain;
  logic rxS;
  logic rxD;
  logic edgeSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= {SYNC_STAGES{1'b1}};
      rxD       <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxPin};
      rxD       <= rxS;
    end
  end

  assign rxS      = syncChain[SYNC_STAGES-1];
  assign edgeSeen = (rxS != rxD);

  // saturating run-length counter
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (edgeSeen) begin
      runCnt <= CNT_W'(1);
    end else if (runCnt != CNT_MAX) begin
      runCnt <= runCnt + CNT_W'(1);
    end
  end

  // stored measurements
  logic [CNT_W-1:0] idleLen;
  logic [CNT_W-1:0] xReg;
  logic [SUM_W-1:0] sumReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      idleLen <= '0;
      xReg    <= '0;
      sumReg  <= '0;
    end else begin
      if (cmd.loadIdle) idleLen <= runCnt;
      if (cmd.loadStart) begin
        xReg   <= runCnt;
        sumReg <= SUM_W'(runCnt);
      end else if (cmd.addRun) begin
        sumReg <= sumReg + SUM_W'(runCnt);
      end
    end
  end

  // checks against the candidate unit period
  logic [EXT_W-1:0] runExt;
  logic [EXT_W-1:0] xExt;
  logic [EXT_W-1:0] idleLimit;
  logic [EXT_W-1:0] runTimes4;
  logic [EXT_W-1:0] kTimes4x;
  logic [EXT_W-1:0] tolLo;
  logic [EXT_W-1:0] tolHi;

  always_comb begin
    runExt    = EXT_W'(runCnt);
    xExt      = EXT_W'(xReg);
    idleLimit = runExt * EXT_W'(IDLE_UNITS);
    runTimes4 = runExt << 2;
    kTimes4x  = xExt << (2 + int'(cmd.tolSel));
    tolLo     = kTimes4x - xExt;
    tolHi     = kTimes4x + xExt;
  end

  assign stat.runDone  = edgeSeen;
  assign stat.runLevel = rxD;
  assign stat.startOk  = (runCnt >= CNT_W'(MIN_START));
  assign stat.idleOk   = (EXT_W'(idleLen) > idleLimit);
  assign stat.inTol    = (runTimes4 >= tolLo) && (runTimes4 <= tolHi);

  // period computation: rounded divide of the full character by nine
  logic [SUM_W-1:0] sumFinal;
  logic [SUM_W:0]   sumRounded;
  logic [SUM_W:0]   quotient;

  always_comb begin
    sumFinal   = sumReg + SUM_W'(runCnt);
    sumRounded = {1'b0, sumFinal} + (SUM_W+1)'(4);
    quotient   = sumRounded / (SUM_W+1)'(9);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitPeriod    <= '0;
      periodValid  <= 1'b0;
      periodUpdate <= 1'b0;
    end else begin
      periodUpdate <= 1'b0;
      if (cmd.commit) begin
        bitPeriod    <= quotient[CNT_W-1:0];
        periodValid  <= 1'b1;
        periodUpdate <= 1'b1;
      end
    end
  end

  // assertions
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    periodUpdate |=> !periodUpdate);

  assert_period_only_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(bitPeriod) |-> periodUpdate);

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(periodValid) |-> periodUpdate);

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    periodValid |=> periodValid);

  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (rst)
    (runCnt == CNT_MAX && !edgeSeen) |=> runCnt == CNT_MAX);

  assert_min_start_R7: assert property (@(posedge clk) disable iff (rst)
    periodUpdate |-> xReg >= CNT_W'(MIN_START));

endmodule

// File: rtl/cr_autobaud_ctl.sv
module cr_autobaud_ctl
  import cr_autobaud_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  dpStat_t stat,
  output ctlCmd_t cmd
);

  ctlState_t state;
  ctlState_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= stateNext;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;

    unique case (state)
      ST_B23:  cmd.tolSel = TOL_K2;
      ST_B47:  cmd.tolSel = TOL_K4;
      default: cmd.tolSel = TOL_K1;
    endcase

    if (stat.runDone) begin
      unique case (state)
        ST_WAIT: begin
          if (stat.runLevel) begin
            cmd.loadIdle = 1'b1;
            stateNext    = ST_START;
          end
        end
        ST_START: begin
          if (stat.startOk && stat.idleOk) begin
            cmd.loadStart = 1'b1;
            stateNext     = ST_B0;
          end else begin
            stateNext = ST_WAIT;
          end
        end
        ST_B0, ST_B1, ST_B23: begin
          if (stat.inTol) begin
            cmd.addRun = 1'b1;
            stateNext  = (state == ST_B0) ? ST_B1 :
                         (state == ST_B1) ? ST_B23 : ST_B47;
          end else if (stat.runLevel) begin
            cmd.loadIdle = 1'b1;
            stateNext    = ST_START;
          end else begin
            stateNext = ST_WAIT;
          end
        end
        ST_B47: begin
          if (stat.inTol) cmd.commit = 1'b1;
          stateNext = ST_WAIT;
        end
        default: stateNext = ST_WAIT;
      endcase
    end
  end

  // a high run that breaks the sequence is reused as the next idle candidate
  assert_abort_reuses_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (stat.runDone && stat.runLevel && state != ST_START && !stat.inTol) |=> state == ST_START);

  assert_commit_leaves_R3: assert property (@(posedge clk) disable iff (rst)
    cmd.commit |=> state == ST_WAIT);

endmodule

// File: rtl/cr_autobaud.sv
module cr_autobaud
  import cr_autobaud_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_START   = 4,
  parameter int IDLE_UNITS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxPin,
  output logic [CNT_W-1:0] bitPeriod,
  output logic             periodValid,
  output logic             periodUpdate
);

  ctlCmd_t cmd;
  dpStat_t stat;

  cr_autobaud_dp #(
    .CNT_W(CNT_W),
    .MIN_START(MIN_START),
    .IDLE_UNITS(IDLE_UNITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dpInst (
    .clk(clk),
    .rst(rst),
    .rxPin(rxPin),
    .cmd(cmd),
    .stat(stat),
    .bitPeriod(bitPeriod),
    .periodValid(periodValid),
    .periodUpdate(periodUpdate)
  );

  cr_autobaud_ctl ctlInst (
    .clk(clk),
    .rst(rst),
    .stat(stat),
    .cmd(cmd)
  );

endmodule

// File: tb/tb_cr_autobaud.sv
`timescale 1ns/1ps
module tb_cr_autobaud;

  localparam int TRAIL   = 20;
  localparam int SAT_MAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxPin = 1'b1;
  logic [15:0] bitPeriod;
  logic periodValid;
  logic periodUpdate;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cr_autobaud dut (
    .clk(clk), .rst(rst), .rxPin(rxPin),
    .bitPeriod(bitPeriod), .periodValid(periodValid), .periodUpdate(periodUpdate)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m1, m2, md, mcnt;
  int q[$];
  int expP, expV, expS;

  function automatic bit prefixOk();
    int n = q.size();
    int x;
    int kk[6] = '{0, 0, 1, 1, 2, 4};
    if (n < 2) return 1;
    x = q[1];
    if (x < 4) return 0;
    if (q[0] <= 8 * x) return 0;
    for (int i = 2; i < n; i++) begin
      if (4 * q[i] < (4 * kk[i] - 1) * x) return 0;
      if (4 * q[i] > (4 * kk[i] + 1) * x) return 0;
    end
    return 1;
  endfunction

  task automatic takeRun(input int lvl, input int len);
    int s;
    if (q.size() == 0) begin
      if (lvl == 1) q.push_back(len);
      return;
    end
    q.push_back(len);
    if (!prefixOk()) begin
      q.delete();
      if (lvl == 1) q.push_back(len);
    end else if (q.size() == 6) begin
      s = q[1] + q[2] + q[3] + q[4] + q[5];
      expP = (s + 4) / 9;
      expV = 1;
      expS = 1;
      q.delete();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m1 = 1; m2 = 1; md = 1; mcnt = 0;
      q.delete();
      expP = 0; expV = 0; expS = 0;
    end else begin
      expS = 0;
      if (m2 != md) takeRun(md, mcnt);
      if (m2 != md) mcnt = 1;
      else if (mcnt < SAT_MAX) mcnt = mcnt + 1;
      md = m2; m2 = m1; m1 = int'(rxPin);
    end
  end

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chkEq("R3", "model bitPeriod", int'(bitPeriod), expP);
      chkEq("R9", "model periodUpdate", int'(periodUpdate), expS);
      chkEq("R8", "model periodValid", int'(periodValid), expV);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input bit lvl, input int n);
    rxPin = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic crBody(input int idle, input int s, input int b0, input int b1,
                        input int b23, input int b47);
    hold(1, idle); hold(0, s); hold(1, b0); hold(0, b1); hold(1, b23); hold(0, b47);
    rxPin = 1'b1;
  endtask

  task automatic sendCr(input int idle, input int s, input int b0, input int b1,
                        input int b23, input int b47);
    crBody(idle, s, b0, b1, b23, b47);
    hold(1, TRAIL);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chkEq("R1", "period in reset", int'(bitPeriod), 0);
    chkEq("R1", "valid in reset", int'(periodValid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R1", "period after reset", int'(bitPeriod), 0);
    chkEq("R1", "valid after reset", int'(periodValid), 0);
    chkEq("R1", "strobe after reset", int'(periodUpdate), 0);

    // R2 latency at 173 clocks per bit
    crBody(2000, 173, 173, 173, 346, 692);
    @(negedge clk);
    @(negedge clk);
    chkEq("R2", "strobe after two edges", int'(periodUpdate), 0);
    @(negedge clk);
    chkEq("R2", "strobe at third edge", int'(periodUpdate), 1);
    chkEq("R3", "period 173", int'(bitPeriod), 173);
    chkEq("R9", "valid with first strobe", int'(periodValid), 1);
    @(negedge clk);
    chkEq("R9", "strobe one cycle", int'(periodUpdate), 0);
    hold(1, TRAIL);

    // R8 rate down then up
    sendCr(400, 20, 20, 20, 40, 80);
    chkEq("R8", "rate down", int'(bitPeriod), 20);
    sendCr(800, 40, 40, 40, 80, 160);
    chkEq("R8", "rate up", int'(bitPeriod), 40);
    chkEq("R8", "valid stays", int'(periodValid), 1);

    // R6 rounding point
    sendCr(400, 20, 20, 20, 40, 84);
    chkEq("R6", "sum 184 rounds down", int'(bitPeriod), 20);
    sendCr(400, 20, 20, 20, 40, 85);
    chkEq("R6", "sum 185 rounds up", int'(bitPeriod), 21);

    // R4 tolerance limits
    sendCr(400, 20, 25, 15, 35, 75);
    chkEq("R4", "all runs at limits", int'(bitPeriod), 19);
    sendCr(400, 20, 26, 20, 40, 80);
    chkEq("R4", "bit0 one over", int'(bitPeriod), 19);
    sendCr(400, 20, 20, 20, 40, 74);
    chkEq("R4", "last run one under", int'(bitPeriod), 19);

    // R5 strict idle bound: total high run = TRAIL + idle
    sendCr(240 - TRAIL, 30, 30, 30, 60, 120);
    chkEq("R5", "idle exactly 8x", int'(bitPeriod), 19);
    sendCr(241 - TRAIL, 30, 30, 30, 60, 120);
    chkEq("R5", "idle 8x plus one", int'(bitPeriod), 30);

    // R7 glitch floor
    sendCr(200, 3, 3, 3, 6, 12);
    chkEq("R7", "start 3 rejected", int'(bitPeriod), 30);
    sendCr(200, 4, 4, 4, 8, 16);
    chkEq("R7", "start 4 accepted", int'(bitPeriod), 4);

    // R11 space character ignored
    hold(1, 500); hold(0, 150); hold(1, 25); hold(0, 50); hold(1, TRAIL);
    chkEq("R11", "space ignored period", int'(bitPeriod), 4);
    chkEq("R11", "space ignored valid", int'(periodValid), 1);

    // R10 counter saturation on a very long idle
    sendCr(65536 + TRAIL, 10, 10, 10, 20, 40);
    chkEq("R10", "long idle accepted", int'(bitPeriod), 10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule